// File: doc/BRIEF.md
# Radix-16 Covalent Redundant-Binary Booth Encoder Slice

This combinational slice turns a five-bit window of a two's complement multiplier into the controls that pick one redundant-binary (RB) partial product in a radix-16 multiplier. Two radix-4 Booth digit encoders share the middle bit of the window. A polarization stage then maps the two signed digits onto a positive/negative pair of easy multiples of the multiplicand, plus a flag that swaps the two halves. Across the slice the multiple lies in [-8, 8]. The only hard multiple needed is 5X, and no correction vector is produced.

A multiplier of width W uses W/4 copies of this slice. Slice l gets the bits y(4l+3) down to y(4l-1), with y(-1) tied to zero for slice 0. Each slice drives two one-hot select vectors. The partial-product generator uses them to pick the plus and minus operands of one RB row, and it uses the swap flag to exchange them.

Top module: `crb16_enc_slice`

## Requirements
- R1: With `y_grp[k]` = y(4l-1+k), the lower digit is d0 = -2·y_grp[2] + y_grp[1] + y_grp[0] and the upper digit is d1 = -2·y_grp[4] + y_grp[3] + y_grp[2], each in {-2..2}.
- R2: Let P and N be the weights of the active lines in `pos_sel` and `neg_sel`, where bit0=1, bit1=2, bit2=4, bit3=8, bit4=5 and an all-zero vector weighs 0. Then P − N = 4·d1 + d0 when `swap` is 0, and N − P = 4·d1 + d0 when `swap` is 1.
- R3: Each of `pos_sel` and `neg_sel` has at most one bit high.
- R4: `swap` equals y_grp[4] when d1 ≠ 0, and it equals the inverse of y_grp[4] when d1 = 0.
- R5: `pos_sel` only ever raises bits 2, 3 or 4 (4X, 8X, 5X). `neg_sel` only ever raises bits 0 or 1 (1X, 2X).
- R6: When d1 ≠ 0 and the digits do not share a nonzero sign, P = 4·|d1| and N = |d0|.
- R7: When both digits are nonzero with the same sign and 4·|d1| + |d0| = 5, `pos_sel` raises the 5X line (bit 4) and `neg_sel` is all zero.
- R8: When both digits are nonzero with the same sign and 4·|d1| + |d0| = 6, the split is P = 8 and N = 2. Same-sign pairs only occur with |d1| = 1.
- R9: When d1 = 0, `pos_sel` is all zero and N = |d0|.
- R10: The window 00000 gives both select vectors zero with `swap` = 1. The window 11111 gives both select vectors zero with `swap` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| y_grp | input | 5 | Multiplier window, bit k = y(4l-1+k) |
| pos_sel | output | 5 | One-hot select of the plus operand (1X,2X,4X,8X,5X on bits 0..4) |
| neg_sel | output | 5 | One-hot select of the minus operand, same bit weights |
| swap | output | 1 | Exchange plus and minus halves to negate the row |

## Verification
All 32 windows are applied in ascending order and then in descending order, so every digit pair is seen after different neighbours. The windows fall into four groups: the upper digit is zero, the digits have opposite signs, the digits share a sign (the only windows that reach the 5X line or the 8−2 split for six), and the lower digit is zero but written with either sign bit. These groups separate a wrong swap polarity from a wrong magnitude split. The all-zero and all-one windows are the two encodings of a zero row, and they show whether the swap rule follows the sign bit or the digit value.

// File: rtl/crb_pkg.sv
package crb_pkg;

   localparam int SEL_W   = 5;
   localparam int SEL_1X  = 0;
   localparam int SEL_2X  = 1;
   localparam int SEL_4X  = 2;
   localparam int SEL_8X  = 3;
   localparam int SEL_5X  = 4;
   localparam int DIGITS  = 2;
   localparam int WIN_W   = 2 * DIGITS + 1;

   typedef struct packed {
      logic sgn;
      logic m2;
      logic m1;
   } r4_digit_t;

   function automatic int line_weight(input int idx);
      case (idx)
         SEL_1X:  return 1;
         SEL_2X:  return 2;
         SEL_4X:  return 4;
         SEL_8X:  return 8;
         SEL_5X:  return 5;
         default: return 0;
      endcase
   endfunction

   function automatic int sel_weight(input logic [SEL_W-1:0] s);
      int acc;
      acc = 0;
      for (int i = 0; i < SEL_W; i++)
         if (s[i]) acc += line_weight(i);
      return acc;
   endfunction

endpackage

// File: rtl/crb_r4_digit.sv
module crb_r4_digit
   import crb_pkg::*;
(
   input  logic [2:0] trio,
   output r4_digit_t  digit
);

   always_comb begin
      digit.sgn = trio[2];
      digit.m1  = trio[1] ^ trio[0];
      digit.m2  = (trio[2] & ~trio[1] & ~trio[0]) | (~trio[2] & trio[1] & trio[0]);
   end

   // R1: a digit is never magnitude 1 and 2 at once
   always_comb begin
      p_mag_excl_r1: assert (!(digit.m1 && digit.m2))
         else $error("digit magnitude lines both high");
   end

endmodule

// File: rtl/crb_polarize.sv
module crb_polarize
   import crb_pkg::*;
(
   input  r4_digit_t        dig_lo,
   input  r4_digit_t        dig_hi,
   output logic [SEL_W-1:0] pos_sel,
   output logic [SEL_W-1:0] neg_sel,
   output logic             swap
);

   logic hi_nz;
   logic lo_nz;
   logic agree;

   assign hi_nz = dig_hi.m2 | dig_hi.m1;
   assign lo_nz = dig_lo.m2 | dig_lo.m1;
   assign agree = hi_nz & lo_nz & (dig_hi.sgn == dig_lo.sgn);
   assign swap  = hi_nz ? dig_hi.sgn : ~dig_hi.sgn;

   always_comb begin
      pos_sel = '0;
      neg_sel = '0;
      if (!hi_nz) begin
         neg_sel[SEL_2X] = dig_lo.m2;
         neg_sel[SEL_1X] = dig_lo.m1;
      end else if (agree) begin
         if (dig_lo.m1) begin
            pos_sel[SEL_5X] = 1'b1;
         end else begin
            pos_sel[SEL_8X] = 1'b1;
            neg_sel[SEL_2X] = 1'b1;
         end
      end else begin
         pos_sel[SEL_8X] = dig_hi.m2;
         pos_sel[SEL_4X] = dig_hi.m1;
         neg_sel[SEL_2X] = dig_lo.m2;
         neg_sel[SEL_1X] = dig_lo.m1;
      end
   end

   always_comb begin
      p_pos_onehot_r3: assert ($onehot0(pos_sel))
         else $error("plus select not one-hot");
      p_neg_onehot_r3: assert ($onehot0(neg_sel))
         else $error("minus select not one-hot");
      p_pos_lines_r5: assert (pos_sel[SEL_2X:SEL_1X] == 2'b00)
         else $error("plus side raised a small line");
      p_neg_lines_r5: assert (neg_sel[SEL_5X:SEL_4X] == 2'b00)
         else $error("minus side raised a large line");
      if (agree) begin
         p_same_upper_r8: assert (dig_hi.m1 && !dig_hi.m2)
            else $error("same-sign pair with upper magnitude 2");
      end
   end

endmodule

// File: rtl/crb16_enc_slice.sv
module crb16_enc_slice
   import crb_pkg::*;
(
   input  logic [4:0] y_grp,
   output logic [4:0] pos_sel,
   output logic [4:0] neg_sel,
   output logic       swap
);

   r4_digit_t dig [DIGITS];

   for (genvar k = 0; k < DIGITS; k++) begin : g_enc
      crb_r4_digit u_enc (
         .trio  (y_grp[2*k+2 : 2*k]),
         .digit (dig[k])
      );
   end

   crb_polarize u_pol (
      .dig_lo  (dig[0]),
      .dig_hi  (dig[1]),
      .pos_sel (pos_sel),
      .neg_sel (neg_sel),
      .swap    (swap)
   );

   int v_in;
   int v_out;

   always_comb begin
      v_in  = 4 * (int'(y_grp[3]) + int'(y_grp[2]) - 2 * int'(y_grp[4]))
            + (int'(y_grp[1]) + int'(y_grp[0]) - 2 * int'(y_grp[2]));
      v_out = sel_weight(pos_sel) - sel_weight(neg_sel);
      if (swap) v_out = -v_out;
   end

   // R2: recombined row value equals the window's radix-16 digit
   always_comb begin
      p_value_r2: assert (v_out == v_in)
         else $error("row value %0d differs from window value %0d", v_out, v_in);
   end

endmodule

// File: tb/crb16_enc_slice_bench.sv
`timescale 1ns/1ps
module crb16_enc_slice_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] y_grp = 5'd0;
   logic [4:0] pos_sel;
   logic [4:0] neg_sel;
   logic       swap;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   crb16_enc_slice u_crb16_enc_slice (
      .y_grp   (y_grp),
      .pos_sel (pos_sel),
      .neg_sel (neg_sel),
      .swap    (swap)
   );

   function automatic int wsum(input logic [4:0] s);
      int w;
      w = 0;
      if (s[0]) w += 1;
      if (s[1]) w += 2;
      if (s[2]) w += 4;
      if (s[3]) w += 8;
      if (s[4]) w += 5;
      return w;
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s window=%b actual=%0d expected=%0d", req, y_grp, act, exp);
      end
   endtask

   task automatic run_window(input logic [4:0] w);
      int d0, d1, v, p_exp, n_exp, p_act, n_act, signed_act;
      bit sw_exp, same;
      @(posedge clk);
      y_grp = w;
      @(negedge clk);
      // R1 reference digits
      d0 = -2 * int'(w[2]) + int'(w[1]) + int'(w[0]);
      d1 = -2 * int'(w[4]) + int'(w[3]) + int'(w[2]);
      v  = 4 * d1 + d0;
      sw_exp = (d1 != 0) ? w[4] : ~w[4];
      same = (d0 != 0) && (d1 != 0) && ((d0 < 0) == (d1 < 0));
      if (d1 == 0) begin
         p_exp = 0; n_exp = iabs(d0);
      end else if (same) begin
         if (4 * iabs(d1) + iabs(d0) == 5) begin p_exp = 5; n_exp = 0; end
         else begin p_exp = 8; n_exp = 2; end
      end else begin
         p_exp = 4 * iabs(d1); n_exp = iabs(d0);
      end
      p_act = wsum(pos_sel);
      n_act = wsum(neg_sel);
      signed_act = swap ? (n_act - p_act) : (p_act - n_act);
      chk(signed_act == v, "R1/R2 value", signed_act, v);
      chk($countones(pos_sel) <= 1, "R3 plus one-hot", $countones(pos_sel), 1);
      chk($countones(neg_sel) <= 1, "R3 minus one-hot", $countones(neg_sel), 1);
      chk(swap == sw_exp, "R4 swap", int'(swap), int'(sw_exp));
      chk(pos_sel[1:0] == 2'b00 && neg_sel[4:2] == 3'b000, "R5 line sides",
          int'({pos_sel, neg_sel}), 0);
      if (d1 != 0 && !same) begin
         chk(p_act == p_exp, "R6 plus", p_act, p_exp);
         chk(n_act == n_exp, "R6 minus", n_act, n_exp);
      end
      if (same && p_exp == 5) begin
         chk(pos_sel == 5'b10000 && neg_sel == 5'b00000, "R7 5X", int'({pos_sel, neg_sel}), 512);
      end
      if (same && p_exp == 8) begin
         chk(p_act == 8 && n_act == 2, "R8 six split", p_act * 16 + n_act, 8 * 16 + 2);
      end
      if (d1 == 0) begin
         chk(pos_sel == 5'b00000, "R9 plus zero", int'(pos_sel), 0);
         chk(n_act == n_exp, "R9 minus", n_act, n_exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: zero window while reset is held
      chk(pos_sel == 5'd0 && neg_sel == 5'd0, "R10 zero window lines", int'({pos_sel, neg_sel}), 0);
      chk(swap == 1'b1, "R10 zero window swap", int'(swap), 1);
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) run_window(5'(i));
      for (int i = 31; i >= 0; i--) run_window(5'(i));
      run_window(5'b11111);
      chk(pos_sel == 5'd0 && neg_sel == 5'd0, "R10 ones window lines", int'({pos_sel, neg_sel}), 0);
      chk(swap == 1'b0, "R10 ones window swap", int'(swap), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule